// File: doc/BRIEF.md
# Buffered SPI Host

This block is a memory-mapped SPI host that moves a whole buffer per start command. Software writes up to 320 bytes into a command buffer, then writes a control word with the byte count, a clock speed code, a bus mode, a device-select number and a start bit. The block shifts the bytes out MSB first. For every byte sent, the byte received on MISO is stored at the same index of a response buffer. When the last byte is done, the start bit clears and a done event is latched. The event drives an interrupt unless it is masked, and software clears it by writing a one.

A forced-select bit keeps the chosen chip-select line low after a run ends. Software can then split one long peripheral transaction into several buffer-sized runs without releasing the select between them. The register port is a plain single-cycle bus. Read data appears one clock after the address.

Top module: `spi_buf_host`

## Requirements
- R1: After reset, the control, event and mask registers read 0, every `cs_n` line is high, `sck` is low and `irq` is low.
- R2: The command buffer is read and written as 32-bit little-endian words at byte addresses 0x000–0x13F. The response buffer reads at 0x200–0x33F. Words beyond byte 319 read as 0.
- R3: A run of N bytes (1 ≤ N ≤ 320) sends command bytes 0..N-1 in order, MSB first, on `mosi`. The byte captured from `miso` during byte k is stored at response index k.
- R4: Let the divider D be the speed code, with codes 0 and 1 treated as 2. Each bit lasts D clocks: `sck` is low for ceil(D/2) clocks, then high for floor(D/2). `miso` is captured on the clock edge that raises `sck`. A run of N bytes ends exactly 8·D·N clocks after the edge that accepted the start write.
- R5: With mode bit 1 (control bit 2), `sck` idles high (mode 3). With mode bit 0 it idles low (mode 0). In both modes the peripheral samples `mosi` on the rising edge of `sck`.
- R6: Control bit 0 (start) reads 1 while a run is in progress and 0 once it ends. A start write with a length of 0 or above 320 is ignored.
- R7: Event bit 8 (address 0x420) is set when a run ends. Writing 1 to bit 8 clears it, and writing 0 leaves it unchanged. If the end of a run and a clearing write fall in the same cycle, the event stays set.
- R8: `irq` is high exactly while event bit 8 is 1 and mask bit 8 (address 0x424) is 0.
- R9: `cs_n[sel]` is low, and all other lines are high, while a run is in progress or forced select is set. Here sel is control bits 27:25. At all other times every line is high.
- R10: With forced select (control bit 4) set, the selected line stays low between consecutive runs. Clearing the bit releases it.
- R11: While a run is in progress, writes to the control register, mask register and command buffer are ignored. Writes to the event register still take effect.
- R12: The control register reads back select at bits 27:25, length at 16:8, speed code at 7:5, forced select at 4, mode at 2 and start/busy at 0. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register bus byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the address of the previous cycle |
| irq | output | 1 | Unmasked done event |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| cs_n | output | 8 | Active-low chip-select lines, one per device number |

## Verification
Two functions can meet on the event bit in the same cycle: the hardware setting it at the end of a run, and a software write that clears it. The bench computes the exact ending edge from 8·D·N. It then times a clearing write so that the write lands on that edge, and expects the event to read back as still set, followed by an `irq` that stays high. The bench also checks the two other orders: a write of zero leaves the event set, and a later clearing write removes it.

// File: rtl/spi_buf_host.sv
module spi_buf_host #(
  parameter int BUF_BYTES = 320,
  parameter int SEL_W     = 3,
  parameter int ADDR_W    = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_we,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  irq,
  output logic                  sck,
  output logic                  mosi,
  input  logic                  miso,
  output logic [(1<<SEL_W)-1:0] cs_n
);
  localparam int NSEL  = 1 << SEL_W;
  localparam int IDX_W = $clog2(BUF_BYTES);
  localparam int LEN_W = 9;
  localparam int WIN_W = 9;
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(12'h400);
  localparam logic [ADDR_W-1:0] A_EVT = ADDR_W'(12'h420);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(12'h424);

  logic [7:0]       cmd_mem [BUF_BYTES];
  logic [7:0]       rsp_mem [BUF_BYTES];
  logic [SEL_W-1:0] sel_q;
  logic [LEN_W-1:0] len_q;
  logic [2:0]       spd_q, bit_q, cnt_q;
  logic             force_q, mode_q, busy_q, evt_q, msk_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       tx_q, rx_q;
  logic [31:0]      cmd_word, rsp_word, ctl_word, rd_next;

  wire in_cmd  = reg_addr[ADDR_W-1:WIN_W] == '0;
  wire in_rsp  = reg_addr[ADDR_W-1:WIN_W] == (ADDR_W-WIN_W)'(1);
  wire is_ctl  = reg_addr == A_CTL;
  wire is_evt  = reg_addr == A_EVT;
  wire is_msk  = reg_addr == A_MSK;
  wire idle_wr = reg_we & ~busy_q;
  wire [LEN_W-1:0] new_len = reg_wdata[16:8];
  wire go_ok = reg_wdata[0] && (new_len != '0) && (int'(new_len) <= BUF_BYTES);
  wire [WIN_W-1:0] wbase = {reg_addr[WIN_W-1:2], 2'b00};

  wire [2:0] div     = (spd_q < 3'd2) ? 3'd2 : spd_q;
  wire [2:0] lo_len  = div - (div >> 1);
  wire bit_end       = busy_q && (cnt_q == div - 3'd1);
  wire capture       = busy_q && (cnt_q == lo_len - 3'd1);
  wire last_byte     = (LEN_W'(idx_q) + LEN_W'(1)) == len_q;
  wire done          = bit_end && (bit_q == 3'd7) && last_byte;
  wire [IDX_W-1:0] idx_nx = idx_q + IDX_W'(1);
  wire evt_clr       = reg_we && is_evt && reg_wdata[8];

  wire unused_wdata = ^{reg_wdata[31:28], reg_wdata[24:17], reg_wdata[3], reg_wdata[1]};

  always_ff @(posedge clk)
    if (idle_wr && in_cmd)
      for (int b = 0; b < 4; b++)
        if (int'(wbase) + b < BUF_BYTES)
          cmd_mem[IDX_W'(int'(wbase) + b)] <= reg_wdata[8*b +: 8];

  always_ff @(posedge clk)
    if (bit_end && bit_q == 3'd7) rsp_mem[idx_q] <= rx_q;

  always_comb begin
    cmd_word = '0;
    rsp_word = '0;
    for (int b = 0; b < 4; b++)
      if (int'(wbase) + b < BUF_BYTES) begin
        cmd_word[8*b +: 8] = cmd_mem[IDX_W'(int'(wbase) + b)];
        rsp_word[8*b +: 8] = rsp_mem[IDX_W'(int'(wbase) + b)];
      end
  end

  assign ctl_word = {4'b0, sel_q, 8'b0, len_q, spd_q, force_q, 1'b0, mode_q, 1'b0, busy_q};

  always_comb begin
    if (in_cmd)      rd_next = cmd_word;
    else if (in_rsp) rd_next = rsp_word;
    else if (is_ctl) rd_next = ctl_word;
    else if (is_evt) rd_next = {23'b0, evt_q, 8'b0};
    else if (is_msk) rd_next = {23'b0, msk_q, 8'b0};
    else             rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0; len_q <= '0; spd_q <= '0; force_q <= 1'b0; mode_q <= 1'b0;
      busy_q <= 1'b0; evt_q <= 1'b0; msk_q <= 1'b0;
      idx_q <= '0; bit_q <= '0; cnt_q <= '0; tx_q <= '0; rx_q <= '0;
    end else begin
      evt_q <= done | (evt_q & ~evt_clr);
      if (idle_wr && is_msk) msk_q <= reg_wdata[8];
      if (idle_wr && is_ctl) begin
        sel_q   <= reg_wdata[27:25];
        len_q   <= new_len;
        spd_q   <= reg_wdata[7:5];
        force_q <= reg_wdata[4];
        mode_q  <= reg_wdata[2];
        if (go_ok) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          bit_q  <= '0;
          cnt_q  <= '0;
          tx_q   <= cmd_mem[0];
        end
      end
      if (busy_q) begin
        cnt_q <= bit_end ? 3'd0 : cnt_q + 3'd1;
        if (capture) rx_q <= {rx_q[6:0], miso};
        if (bit_end) begin
          bit_q <= bit_q + 3'd1;
          if (bit_q != 3'd7) tx_q <= {tx_q[6:0], 1'b0};
          else if (last_byte) busy_q <= 1'b0;
          else begin
            idx_q <= idx_nx;
            tx_q  <= cmd_mem[idx_nx];
          end
        end
      end
    end
  end

  assign sck  = busy_q ? (cnt_q >= lo_len) : mode_q;
  assign mosi = busy_q & tx_q[7];
  assign irq  = evt_q & ~msk_q;

  for (genvar i = 0; i < NSEL; i++) begin : g_cs
    assign cs_n[i] = ~((busy_q | force_q) && (sel_q == SEL_W'(i)));
  end
endmodule

// File: rtl/spi_buf_host_chk.sv
module spi_buf_host_chk #(
  parameter int SEL_W  = 3,
  parameter int LEN_W  = 9,
  parameter int ADDR_W = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  evt,
  input logic                  force_ce,
  input logic                  mode,
  input logic [LEN_W-1:0]      len,
  input logic [SEL_W-1:0]      sel,
  input logic                  sck,
  input logic [(1<<SEL_W)-1:0] cs_n,
  input logic                  reg_we,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [31:0]           reg_wdata
);
  a_r9_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  a_r7_end_sets_event: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> evt);

  a_r7_event_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    evt && !(reg_we && reg_addr == ADDR_W'(12'h420) && reg_wdata[8]) |=> evt);

  a_r4_sck_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) && $stable(mode) |-> $stable(sck));

  a_r10_forced_hold: assert property (@(posedge clk) disable iff (!rst_n)
    force_ce && !busy |-> !(&cs_n));

  a_r11_frozen_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(len) && $stable(sel) && $stable(mode));
endmodule

bind spi_buf_host spi_buf_host_chk #(.SEL_W(SEL_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .evt(evt_q), .force_ce(force_q),
  .mode(mode_q), .len(len_q), .sel(sel_q), .sck(sck), .cs_n(cs_n),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata));

// File: tb/sim_spi_buf_host.sv
`timescale 1ns/1ps
module sim_spi_buf_host;
  localparam logic [11:0] A_CTL = 12'h400, A_EVT = 12'h420, A_MSK = 12'h424, A_RSP = 12'h200;
  // {mode, speed[2:0], len[8:0], sel[2:0]}
  localparam logic [15:0] VEC [7] = '{
    {1'b0, 3'd2, 9'd1,   3'd0},
    {1'b1, 3'd3, 9'd5,   3'd3},
    {1'b0, 3'd7, 9'd4,   3'd7},
    {1'b1, 3'd2, 9'd320, 3'd1},
    {1'b0, 3'd0, 9'd3,   3'd2},
    {1'b1, 3'd5, 9'd6,   3'd5},
    {1'b0, 3'd1, 9'd2,   3'd6}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic reg_we = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, sck, mosi, miso;
  logic [7:0] cs_n;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  spi_buf_host u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n));

  always #4 clk = ~clk;

  function automatic logic [7:0] pat(int i, int s);
    return 8'((i * 7 + s * 31 + 1) & 255);
  endfunction
  function automatic logic [7:0] rep(int n);
    return 8'((n * 29 + 90) & 255);
  endfunction
  function automatic logic [31:0] mkctl(bit go, int len, int spd, bit frc, bit md, int sel);
    return {4'b0, 3'(sel), 8'b0, 9'(len), 3'(spd), frc, 1'b0, md, 1'b0, go};
  endfunction

  // peripheral model: samples mosi on rising sck, answers rep(n) MSB first
  logic [7:0] rx_bytes [1024];
  logic [7:0] slv_sh = '0;
  int nb = 0, bits = 0;
  logic [7:0] rb;
  assign rb = rep(nb);
  assign miso = rb[3'(7 - bits)];
  always @(posedge sck) if (cs_n != 8'hFF) begin
    slv_sh = {slv_sh[6:0], mosi};
    if (bits == 7) begin rx_bytes[nb % 1024] = slv_sh; nb = nb + 1; bits = 0; end
    else bits = bits + 1;
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin n_fail++; $display("FAIL %s: got %h expected %h", tag, act, exp); end
  endtask
  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask
  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a; reg_we = 1'b0;
    @(negedge clk);
    d = reg_rdata;
  endtask
  task automatic fill(int len, int s);
    for (int w = 0; w < (len + 3) / 4; w++)
      wr(12'(4 * w), {pat(4*w+3, s), pat(4*w+2, s), pat(4*w+1, s), pat(4*w, s)});
  endtask
  task automatic wait_done();
    logic [31:0] d;
    for (int n = 0; n < 20000; n++) begin
      rd(A_CTL, d);
      if (!d[0]) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got %h expected %h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int nb0, errs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cs_n == 8'hFF && sck == 1'b0 && irq == 1'b0, "R1 pins", {cs_n, sck, irq}, {8'hFF, 2'b00});
    rd(A_CTL, d); chk(d == 0, "R1 ctl", d, 0);
    rd(A_EVT, d); chk(d == 0, "R1 evt", d, 0);
    rd(A_MSK, d); chk(d == 0, "R1 mask", d, 0);

    // R2 buffer access
    wr(12'h000, 32'h11223344); rd(12'h000, d); chk(d == 32'h11223344, "R2 first word", d, 32'h11223344);
    wr(12'h13C, 32'hA1B2C3D4); rd(12'h13C, d); chk(d == 32'hA1B2C3D4, "R2 last word", d, 32'hA1B2C3D4);
    wr(12'h140, 32'hFFFFFFFF); rd(12'h140, d); chk(d == 0, "R2 beyond end", d, 0);

    // table of runs: R3 R4 R5 R9 R12
    for (int v = 0; v < 7; v++) begin
      automatic bit md = VEC[v][15];
      automatic int spd = int'(VEC[v][14:12]);
      automatic int len = int'(VEC[v][11:3]);
      automatic int sel = int'(VEC[v][2:0]);
      automatic int dv = (spd < 2) ? 2 : spd;
      nb0 = nb;
      fill(len, v);
      wr(A_CTL, mkctl(1, len, spd, 0, md, sel));
      repeat (8 * dv * len - 1) @(negedge clk);
      chk(cs_n == ~(8'(1) << sel), "R4 still busy at last cycle", cs_n, ~(8'(1) << sel));
      @(negedge clk);
      chk(cs_n == 8'hFF, "R4 R9 released at 8*D*N", cs_n, 8'hFF);
      chk(irq == 1'b1, "R8 irq after run", irq, 1);
      chk(sck == md, "R5 idle level", sck, md);
      rd(A_CTL, d); chk(d == mkctl(0, len, spd, 0, md, sel), "R12 R6 ctl readback", d, mkctl(0, len, spd, 0, md, sel));
      rd(A_EVT, d); chk(d == 32'h100, "R7 event set", d, 32'h100);
      errs = 0;
      for (int i = 0; i < len; i++) if (rx_bytes[(nb0 + i) % 1024] !== pat(i, v)) errs++;
      chk(errs == 0 && nb == nb0 + len, "R3 mosi bytes", errs, 0);
      errs = 0;
      for (int w = 0; w < (len + 3) / 4; w++) begin
        rd(A_RSP + 12'(4 * w), d);
        for (int b = 0; b < 4; b++)
          if (4 * w + b < len && d[8*b +: 8] !== rep(nb0 + 4 * w + b)) errs++;
      end
      chk(errs == 0, "R3 response buffer", errs, 0);
      wr(A_EVT, 32'h100);
      chk(irq == 1'b0, "R7 clear", irq, 0);
    end

    // R6 invalid lengths ignored
    wr(A_CTL, mkctl(1, 0, 2, 0, 0, 1));
    repeat (20) @(negedge clk);
    rd(A_CTL, d); chk(d[0] == 1'b0, "R6 len 0 ignored", d, 0);
    wr(A_CTL, mkctl(1, 321, 2, 0, 0, 1));
    repeat (20) @(negedge clk);
    rd(A_CTL, d); chk(d[0] == 1'b0, "R6 len 321 ignored", d, 0);
    rd(A_EVT, d); chk(d == 0 && cs_n == 8'hFF, "R6 no run", {d[23:0], cs_n}, 32'hFF);

    // R11 writes ignored while busy
    fill(4, 10);
    wr(A_CTL, mkctl(1, 4, 7, 0, 0, 2));
    wr(A_CTL, mkctl(1, 9, 3, 1, 0, 5));
    wr(12'h000, 32'hDEADBEEF);
    wr(A_MSK, 32'h100);
    rd(A_CTL, d); chk(d == mkctl(1, 4, 7, 0, 0, 2), "R11 R6 ctl while busy", d, mkctl(1, 4, 7, 0, 0, 2));
    wait_done();
    rd(A_CTL, d); chk(d == mkctl(0, 4, 7, 0, 0, 2), "R11 ctl after run", d, mkctl(0, 4, 7, 0, 0, 2));
    rd(12'h000, d); chk(d == {pat(3,10), pat(2,10), pat(1,10), pat(0,10)}, "R11 cmd buffer kept", d, {pat(3,10), pat(2,10), pat(1,10), pat(0,10)});
    rd(A_MSK, d); chk(d == 0 && irq == 1'b1, "R11 mask kept", {d[30:0], irq}, 1);
    wr(A_EVT, 32'h100);

    // R7 end of run and clearing write on the same edge
    fill(1, 11);
    wr(A_CTL, mkctl(1, 1, 2, 0, 0, 0));
    repeat (15) @(negedge clk);
    wr(A_EVT, 32'h100);
    rd(A_EVT, d); chk(d == 32'h100, "R7 set wins over clear", d, 32'h100);
    wr(A_EVT, 32'h0);
    rd(A_EVT, d); chk(d == 32'h100, "R7 write zero no effect", d, 32'h100);
    wr(A_EVT, 32'h100);
    rd(A_EVT, d); chk(d == 0, "R7 write one clears", d, 0);

    // R8 mask
    wr(A_CTL, mkctl(1, 1, 2, 0, 0, 0));
    wait_done();
    wr(A_MSK, 32'h100);
    rd(A_EVT, d); chk(d == 32'h100 && irq == 1'b0, "R8 masked", {d[30:0], irq}, 32'h200);
    wr(A_MSK, 32'h0);
    chk(irq == 1'b1, "R8 unmasked", irq, 1);
    wr(A_EVT, 32'h100);

    // R10 forced select across two runs
    nb0 = nb;
    fill(2, 12);
    wr(A_CTL, mkctl(1, 2, 3, 1, 0, 4));
    wait_done();
    chk(cs_n == 8'hEF, "R10 held after first run", cs_n, 8'hEF);
    wr(A_EVT, 32'h100);
    fill(2, 13);
    wr(A_CTL, mkctl(1, 2, 3, 1, 0, 4));
    wait_done();
    chk(cs_n == 8'hEF, "R10 held after second run", cs_n, 8'hEF);
    errs = 0;
    if (rx_bytes[nb0 % 1024] !== pat(0, 12)) errs++;
    if (rx_bytes[(nb0 + 1) % 1024] !== pat(1, 12)) errs++;
    if (rx_bytes[(nb0 + 2) % 1024] !== pat(0, 13)) errs++;
    if (rx_bytes[(nb0 + 3) % 1024] !== pat(1, 13)) errs++;
    chk(errs == 0 && nb == nb0 + 4, "R10 joined stream", errs, 0);
    wr(A_CTL, mkctl(0, 2, 3, 0, 0, 4));
    chk(cs_n == 8'hFF, "R10 R9 released", cs_n, 8'hFF);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule